// File: doc/BRIEF.md
# Three-Level Virtual Address Translator

This block turns a 39-bit virtual address into a 56-bit physical address. It follows a three-level radix tree of translation tables that lives in ordinary memory. Each request carries three things: the virtual address, a mode code that switches translation on or off, and the root table's page number. The request also carries an address space tag, which the block returns with the answer. The block then fetches one 64-bit table entry per level through a request/response memory port. It ends with either a physical address or a fault flag.

A caller hands over one request and waits for the single-cycle answer pulse. Only then may it present the next request. In pass-through mode the block returns the virtual address unchanged, with no memory traffic. In translating mode the walk can stop at any level where it finds a leaf entry. A leaf found above the last level maps a large page: 2 MiB at the middle level, 1 GiB at the top level.

Top module: `sv39_walker`

## Requirements
- R1: With mode code 0 the request completes one cycle after acceptance with `rsp_paddr` equal to the zero-extended virtual address, `rsp_fault` low and no memory request; any nonzero mode code (8 is the usual one) starts a table walk.
- R2: Each walk read goes to `{table_ppn, 12'b0} + index*8`. The table page number is the request's root at the top level and the previous entry's page number below it. The index is VA[38:30], then VA[29:21], then VA[20:12]. Exactly one read is issued per level visited.
- R3: Entry encoding: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bits 53:10 the 44-bit page number (26+9+9 bits, top field highest). An entry with read or execute set is a leaf. An entry with read, write and execute all clear points to the next table.
- R4: A leaf at the last level yields `{entry_ppn, VA[11:0]}`.
- R5: A leaf at the middle level yields `{entry_ppn[43:9], VA[20:12], VA[11:0]}`. A leaf at the top level yields `{entry_ppn[43:18], VA[29:12], VA[11:0]}`.
- R6: A middle-level leaf whose entry_ppn[8:0] is nonzero faults. So does a top-level leaf whose entry_ppn[17:0] is nonzero.
- R7: An entry with valid clear, or with write set and read clear, faults at once, and no further read is issued.
- R8: A pointer entry found at the last level faults after the third read.
- R9: A faulting response has `rsp_fault` high and `rsp_paddr` zero.
- R10: `req_ready` is low from acceptance until the cycle after the response. `rsp_valid` is a one-cycle pulse. `rsp_asid` returns the request's address space tag.
- R11: While `mem_req_valid` is high and `mem_req_ready` low, the request and its address hold. After an accepted read, no new read is issued until its response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle when valid |
| req_vaddr | input | 39 | Virtual address to translate |
| req_mode | input | 4 | Translation mode code, 0 = pass-through |
| req_asid | input | 16 | Address space tag |
| req_root | input | 44 | Root table page number |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Table entry read |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 56 | Physical address, zero on fault |
| rsp_fault | output | 1 | Translation fault |
| rsp_asid | output | 16 | Tag of the finished request |

## Verification
The bench builds the walker with its default widths: 9-bit indices, 12-bit offset, 44-bit page numbers and three levels. With these, a table memory of only a handful of entries, rebuilt before each request, covers any walk. The bench sweeps every combination of four corner index values (0, 1, 256, 511) at all three levels. While it does so it varies the memory ready pattern and the response delay, so each level's address formation and stall handling are exercised. Large-page merges, alignment faults, invalid and write-only entries at each level, the last-level pointer and pass-through are then checked against addresses the bench computes by concatenation.

// File: rtl/sv39_pkg.sv
package sv39_pkg;
    localparam int SV_VA_W    = 39;
    localparam int SV_PA_W    = 56;
    localparam int SV_PPN_W   = 44;
    localparam int SV_IDX_W   = 9;
    localparam int SV_OFF_W   = 12;
    localparam int SV_LEVELS  = 3;
    localparam int SV_PTE_W   = 64;
    localparam int SV_PPN_LSB = 10;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_REQ,
        WK_WAIT,
        WK_DONE
    } walk_st_e;
endpackage

// File: rtl/sv39_entry_addr.sv
module sv39_entry_addr #(
    parameter int PPN_W  = 44,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 3,
    parameter int PTE_W  = 64,
    parameter int PA_W   = 56,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic [PPN_W-1:0]        base_ppn,
    input  logic [LEVELS*IDX_W-1:0] vpn,
    input  logic [LVL_W-1:0]        lvl,
    output logic [PA_W-1:0]         addr
);
    localparam int ESH = $clog2(PTE_W / 8);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i)) idx = vpn[i*IDX_W +: IDX_W];
        end
    end

    assign addr = PA_W'({base_ppn, {OFF_W{1'b0}}}) | PA_W'({idx, {ESH{1'b0}}});
endmodule

// File: rtl/sv39_pte_eval.sv
module sv39_pte_eval #(
    parameter int PPN_W  = 44,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 3,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic [3:0]              flags,
    input  logic [PPN_W-1:0]        ppn,
    input  logic [LVL_W-1:0]        lvl,
    input  logic [LEVELS*IDX_W-1:0] vpn,
    output logic                    is_leaf,
    output logic                    is_fault,
    output logic [PPN_W-1:0]        leaf_ppn
);
    logic [PPN_W-1:0] mask_tab [LEVELS];
    logic [PPN_W-1:0] low_mask;
    logic [PPN_W-1:0] vpn_ext;
    logic             f_v, f_r, f_w, f_x, misalign;

    // Per-level mask of the page-number bits a large page takes from the VA
    for (genvar g = 0; g < LEVELS; g++) begin : g_mask
        assign mask_tab[g] = PPN_W'((64'd1 << (g * IDX_W)) - 64'd1);
    end

    always_comb begin
        low_mask = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i)) low_mask = mask_tab[i];
        end
    end

    assign {f_x, f_w, f_r, f_v} = flags;
    assign vpn_ext  = PPN_W'(vpn);
    assign misalign = |(ppn & low_mask);
    assign is_leaf  = f_r | f_x;
    assign is_fault = !f_v || (f_w && !f_r) || (is_leaf && misalign)
                    || (!is_leaf && lvl == '0);
    assign leaf_ppn = (ppn & ~low_mask) | (vpn_ext & low_mask);
endmodule

// File: rtl/sv39_walker.sv
module sv39_walker
    import sv39_pkg::*;
#(
    parameter int VA_W    = SV_VA_W,
    parameter int PA_W    = SV_PA_W,
    parameter int PPN_W   = SV_PPN_W,
    parameter int IDX_W   = SV_IDX_W,
    parameter int OFF_W   = SV_OFF_W,
    parameter int LEVELS  = SV_LEVELS,
    parameter int PTE_W   = SV_PTE_W,
    parameter int ASID_W  = 16,
    parameter int MODE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [PPN_W-1:0]  req_root,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_fault,
    output logic [ASID_W-1:0] rsp_asid
);
    localparam int LVL_W  = $clog2(LEVELS);
    localparam int VPN_W  = LEVELS * IDX_W;
    localparam int PLSB   = SV_PPN_LSB;

    typedef struct packed {
        walk_st_e          st;
        logic [VA_W-1:0]   va;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  base;
        logic [LVL_W-1:0]  lvl;
        logic [PA_W-1:0]   pa;
        logic              flt;
    } walk_t;

    walk_t s_d, s_q;

    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ent_ppn, leaf_ppn;
    logic             ent_leaf, ent_fault;
    logic             unused_pte_bits;

    assign vpn_q   = s_q.va[VA_W-1:OFF_W];
    assign ent_ppn = mem_rsp_data[PLSB +: PPN_W];
    assign unused_pte_bits = ^{mem_rsp_data[PTE_W-1:PLSB+PPN_W], mem_rsp_data[PLSB-1:4]};

    sv39_entry_addr #(
        .PPN_W(PPN_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS),
        .PTE_W(PTE_W), .PA_W(PA_W), .LVL_W(LVL_W)
    ) u_addr (
        .base_ppn (s_q.base),
        .vpn      (vpn_q),
        .lvl      (s_q.lvl),
        .addr     (mem_req_addr)
    );

    sv39_pte_eval #(
        .PPN_W(PPN_W), .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
    ) u_eval (
        .flags    (mem_rsp_data[3:0]),
        .ppn      (ent_ppn),
        .lvl      (s_q.lvl),
        .vpn      (vpn_q),
        .is_leaf  (ent_leaf),
        .is_fault (ent_fault),
        .leaf_ppn (leaf_ppn)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            WK_IDLE: begin
                if (req_valid) begin
                    s_d.va   = req_vaddr;
                    s_d.asid = req_asid;
                    if (req_mode == '0) begin
                        s_d.pa  = PA_W'(req_vaddr);
                        s_d.flt = 1'b0;
                        s_d.st  = WK_DONE;
                    end else begin
                        s_d.base = req_root;
                        s_d.lvl  = LVL_W'(LEVELS - 1);
                        s_d.st   = WK_REQ;
                    end
                end
            end
            WK_REQ: begin
                if (mem_req_ready) s_d.st = WK_WAIT;
            end
            WK_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ent_fault) begin
                        s_d.flt = 1'b1;
                        s_d.pa  = '0;
                        s_d.st  = WK_DONE;
                    end else if (ent_leaf) begin
                        s_d.flt = 1'b0;
                        s_d.pa  = PA_W'({leaf_ppn, s_q.va[OFF_W-1:0]});
                        s_d.st  = WK_DONE;
                    end else begin
                        s_d.base = ent_ppn;
                        s_d.lvl  = s_q.lvl - 1'b1;
                        s_d.st   = WK_REQ;
                    end
                end
            end
            default: s_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: WK_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready     = (s_q.st == WK_IDLE);
    assign mem_req_valid = (s_q.st == WK_REQ);
    assign rsp_valid     = (s_q.st == WK_DONE);
    assign rsp_paddr     = s_q.pa;
    assign rsp_fault     = s_q.flt;
    assign rsp_asid      = s_q.asid;

    // R1: pass-through answers in the next cycle with the VA itself
    a_r1_bare_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode == '0) |=>
            (rsp_valid && !rsp_fault && !mem_req_valid && rsp_paddr == PA_W'($past(req_vaddr))));

    // R9: a fault never leaks an address
    a_r9_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R10: busy while answering, answer is a single pulse
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11: stalled read holds, one read outstanding
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
endmodule

// File: tb/sim_sv39_walker.sv
module sim_sv39_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [38:0] req_vaddr = '0;
    logic [3:0]  req_mode = '0;
    logic [15:0] req_asid = '0;
    logic [43:0] req_root = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [55:0] rsp_paddr;
    logic        rsp_fault;
    logic [15:0] rsp_asid;

    always #4 clk = ~clk;

    sv39_walker u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_mode(req_mode), .req_asid(req_asid), .req_root(req_root),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_asid(rsp_asid)
    );

    logic [63:0] mem [logic [55:0]];
    int checks = 0;
    int failures = 0;
    int lat_sel = 0;
    int rdy_pat = 0;
    bit done = 0;

    logic [55:0] r_pa;
    logic        r_flt;
    logic [15:0] r_asid;
    int          r_reads;
    int          r_lat;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [43:0] ppn, input logic [9:0] fl);
        return {10'b0, ppn, fl};
    endfunction

    function automatic logic [55:0] ea(input logic [43:0] base, input logic [8:0] idx);
        return {base, 12'b0} + {44'b0, idx, 3'b0};
    endfunction

    task automatic xlate(input logic [38:0] va, input logic [3:0] mode,
                         input logic [43:0] root, input logic [15:0] asid);
        bit sent = 0, pend = 0, got = 0;
        int cnt = 0, cyc = 0, acc = 0;
        logic [55:0] paddr_q = '0;
        r_reads = 0; r_lat = 0; r_pa = 'x; r_flt = 'x; r_asid = 'x;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_mode = mode; req_root = root; req_asid = asid;
        while (!got && cyc < 300) begin
            mem_req_ready = ((rdy_pat + cyc) % 3) != 1;
            if (req_valid && req_ready && !sent) begin sent = 1; acc = cyc; end
            if (mem_req_valid && mem_req_ready) begin
                r_reads++; pend = 1; paddr_q = mem_req_addr; cnt = lat_sel;
            end
            @(negedge clk);
            cyc++;
            if (sent) req_valid = 1'b0;
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = mem.exists(paddr_q) ? mem[paddr_q] : 64'h0;
                    pend = 0;
                end else cnt--;
            end
            if (rsp_valid) begin
                got = 1; r_pa = rsp_paddr; r_flt = rsp_fault; r_asid = rsp_asid; r_lat = cyc - acc;
            end
        end
        chk("R10", "response arrived", 64'(got), 64'd1);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        // R10: pulse ended, idle again
        chk("R10", "pulse length", 64'(rsp_valid), 64'd0);
        chk("R10", "ready after response", 64'(req_ready), 64'd1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL R10 watchdog actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [8:0] cv [4];
        logic [9:0] lf [4];
        cv[0] = 9'd0; cv[1] = 9'd1; cv[2] = 9'h100; cv[3] = 9'h1FF;
        lf[0] = 10'h0C7; lf[1] = 10'h00B; lf[2] = 10'h009; lf[3] = 10'h003;

        repeat (3) @(negedge clk);
        // reset state
        chk("R10", "reset ready", 64'(req_ready), 64'd1);
        chk("R10", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R11", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        // R1: pass-through
        for (int k = 0; k < 4; k++) begin
            logic [38:0] va;
            va = (k == 0) ? 39'h0 : (k == 1) ? 39'h7F_FFFF_FFFF :
                 (k == 2) ? 39'h55_5555_5555 : 39'h00_0000_1234;
            xlate(va, 4'h0, 44'h777, 16'hB000 + 16'(k));
            chk("R1", "bare paddr", 64'(r_pa), 64'(va));
            chk("R1", "bare fault", 64'(r_flt), 64'd0);
            chk("R1", "bare reads", 64'(r_reads), 64'd0);
            chk("R1", "bare latency", 64'(r_lat), 64'd1);
            chk("R10", "bare asid", 64'(r_asid), 64'(16'hB000 + 16'(k)));
        end

        // R2 R3 R4 R11: full walks over index corners, stalls and delays varied
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                for (int c = 0; c < 4; c++) begin
                    logic [43:0] root, t1, t0, leaf;
                    logic [11:0] off;
                    root = 44'h12345 + 44'(a);
                    t1   = 44'hA0000 + 44'(b * 16 + a);
                    t0   = 44'hB0000 + 44'(c * 16 + b);
                    leaf = 44'hABCDEF01234 + 44'(a * 100 + b * 10 + c);
                    off  = 12'((a * 12'h155 + b * 12'h2A + c * 7) & 12'hFFF);
                    mem.delete();
                    mem[ea(root, cv[a])] = mk(t1, 10'h001);
                    mem[ea(t1, cv[b])]   = mk(t0, 10'h001);
                    mem[ea(t0, cv[c])]   = mk(leaf, lf[(a + b + c) % 4]);
                    lat_sel = c % 3;
                    rdy_pat = a + b;
                    xlate({cv[a], cv[b], cv[c], off}, 4'h8, root, 16'(a * 16 + b * 4 + c));
                    chk("R4", "4K paddr", 64'(r_pa), 64'({leaf, off}));
                    chk("R3", "4K fault", 64'(r_flt), 64'd0);
                    chk("R2", "4K reads", 64'(r_reads), 64'd3);
                    chk("R10", "asid echo", 64'(r_asid), 64'(a * 16 + b * 4 + c));
                end
            end
        end

        // R5: 2 MiB and 1 GiB leaves
        for (int k = 0; k < 4; k++) begin
            logic [43:0] root, t1, big;
            logic [38:0] va;
            root = 44'h300; t1 = 44'h301; big = 44'h12345678000;
            va = {9'h0A5, cv[3 - k], cv[k], 12'hABC};
            mem.delete();
            mem[ea(root, 9'h0A5)] = mk(t1, 10'h001);
            mem[ea(t1, cv[3 - k])] = mk(big, 10'h00B);
            lat_sel = k % 2; rdy_pat = k;
            xlate(va, 4'h8, root, 16'h1);
            chk("R5", "2M paddr", 64'(r_pa), 64'({big[43:9], cv[k], 12'hABC}));
            chk("R5", "2M reads", 64'(r_reads), 64'd2);

            big = 44'h12345600000;
            mem.delete();
            mem[ea(root, cv[k])] = mk(big, 10'h0C7);
            xlate({cv[k], cv[3 - k], cv[k], 12'h5A5}, 4'h8, root, 16'h2);
            chk("R5", "1G paddr", 64'(r_pa), 64'({big[43:18], cv[3 - k], cv[k], 12'h5A5}));
            chk("R5", "1G reads", 64'(r_reads), 64'd1);
        end

        lat_sel = 1; rdy_pat = 0;
        // R6: misaligned large pages
        mem.delete();
        mem[ea(44'h300, 9'h3)] = mk(44'h301, 10'h001);
        mem[ea(44'h301, 9'h4)] = mk(44'h12345678001, 10'h003);
        xlate({9'h3, 9'h4, 9'h5, 12'h0}, 4'h8, 44'h300, 16'h3);
        chk("R6", "2M misaligned fault", 64'(r_flt), 64'd1);
        chk("R9", "2M misaligned paddr", 64'(r_pa), 64'd0);
        chk("R6", "2M misaligned reads", 64'(r_reads), 64'd2);
        mem.delete();
        mem[ea(44'h300, 9'h3)] = mk(44'h12345600200, 10'h003);
        xlate({9'h3, 9'h4, 9'h5, 12'h0}, 4'h8, 44'h300, 16'h3);
        chk("R6", "1G misaligned fault", 64'(r_flt), 64'd1);
        chk("R6", "1G misaligned reads", 64'(r_reads), 64'd1);

        // R7: invalid entry at each level stops the walk there
        for (int l = 1; l <= 3; l++) begin
            mem.delete();
            mem[ea(44'h400, 9'h11)] = mk(44'h401, (l == 1) ? 10'h006 : 10'h001);
            mem[ea(44'h401, 9'h22)] = mk(44'h402, (l == 2) ? 10'h00A : 10'h001);
            mem[ea(44'h402, 9'h33)] = mk(44'h999, (l == 3) ? 10'h0C6 : 10'h003);
            xlate({9'h11, 9'h22, 9'h33, 12'h1}, 4'h8, 44'h400, 16'h4);
            chk("R7", "invalid fault", 64'(r_flt), 64'd1);
            chk("R7", "invalid reads", 64'(r_reads), 64'(l));
            chk("R9", "invalid paddr", 64'(r_pa), 64'd0);
        end

        // R7: write without read, with and without execute
        for (int k = 0; k < 2; k++) begin
            mem.delete();
            mem[ea(44'h400, 9'h11)] = mk(44'h401, 10'h001);
            mem[ea(44'h401, 9'h22)] = mk(44'h402, 10'h001);
            mem[ea(44'h402, 9'h33)] = mk(44'h999, (k == 0) ? 10'h005 : 10'h00D);
            xlate({9'h11, 9'h22, 9'h33, 12'h1}, 4'h8, 44'h400, 16'h5);
            chk("R7", "write-only fault", 64'(r_flt), 64'd1);
        end

        // R8: pointer at the last level
        mem.delete();
        mem[ea(44'h400, 9'h11)] = mk(44'h401, 10'h001);
        mem[ea(44'h401, 9'h22)] = mk(44'h402, 10'h001);
        mem[ea(44'h402, 9'h33)] = mk(44'h403, 10'h001);
        xlate({9'h11, 9'h22, 9'h33, 12'h1}, 4'h8, 44'h400, 16'h6);
        chk("R8", "last-level pointer fault", 64'(r_flt), 64'd1);
        chk("R8", "last-level pointer reads", 64'(r_reads), 64'd3);
        chk("R9", "last-level pointer paddr", 64'(r_pa), 64'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule